// File: doc/BRIEF.md
# Programmable Non-Uniform Two-Phase Clock Generator

This block drives the switch clocks of a switched-capacitor filter from one fast clock. Time is cut into frames. A frame holds `m` master periods, called slots, and one frame stands for one conventional sampling period. Every master period is four fast-clock cycles long: phase 1, a dead cycle, phase 2 and a dead cycle. Because of this layout, the two phases of a pair can never overlap.

There are `N_BR` programmable branches. Each one gets its own phase pair. That pair pulses only in slots 1 through `p_i` of each frame and stays idle for the rest of the frame. The ratio `m/p_i` therefore scales the equivalent resistance of that branch. One further shared pair pulses in every slot, for the branches that are not programmed.

The frame length and the per-branch counts are plain control inputs. They are sampled only at a frame boundary. An illegal count is clamped to the nearest legal value, and a per-branch flag reports the clamp. A one-cycle strobe marks the start of every frame. The block has no streaming data path, so it has no valid/ready handshake. All pins are plain control and clock outputs.

Top module: `nupc_phase_gen`

## Requirements
- R1: A frame lasts exactly 4·m fast-clock cycles. Here m is the 6-bit `frame_len` value latched at the frame boundary, and a value of 0 is treated as 1. The lengths 8, 24 and 32 all work.
- R2: In each frame, every programmable branch gives exactly p_i pulses on its phase 1 output and p_i pulses on its phase 2 output. Each pulse is one fast cycle wide.
- R3: Within a frame, cycle k (counted from 0 at the frame start) belongs to slot k/4+1 and sub-cycle k mod 4. A branch's phase 1 is high in sub-cycle 0 and its phase 2 is high in sub-cycle 2, only in slots 1..p_i. Both phases are low in sub-cycles 1 and 3.
- R4: The phase 1 and phase 2 outputs of any pair are never high in the same cycle.
- R5: The shared pair pulses in every slot of every frame. Phase 1 is high in sub-cycle 0 and phase 2 in sub-cycle 2.
- R6: Changes to `frame_len` or to any count take effect only at the next frame boundary. A frame in progress keeps the values it started with.
- R7: A count of 0 acts as 1, and a count above m acts as m. When either happens, that branch's `clamp_flag` bit is high for the whole frame. It is low for a legal count.
- R8: `frame_start` is high for exactly one fast cycle, the first cycle of slot 1 of every frame.
- R9: While `rst_n` is low, every output is low. The first frame begins on the first rising clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four cycles per master period |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_len | input | CNT_W | Slots per frame (m); 0 acts as 1 |
| pulse_cnt | input | N_BR·CNT_W | Per-branch active slot counts; branch i in bits [i·CNT_W +: CNT_W] |
| br_ph1 | output | N_BR | Phase 1 of each programmable branch |
| br_ph2 | output | N_BR | Phase 2 of each programmable branch |
| fix_ph1 | output | 1 | Phase 1 of the always-active pair |
| fix_ph2 | output | 1 | Phase 2 of the always-active pair |
| frame_start | output | 1 | One-cycle strobe on the first cycle of each frame |
| clamp_flag | output | N_BR | Per-branch flag: the count for this frame was clamped |

## Verification
Every output is a register loaded from next-state logic, so each output value shows up one cycle after the edge that decides it. The edge that latches new settings is the same edge that raises `frame_start`. The first cycle of each frame therefore already reflects that frame's settings, and cycle k of the frame has a known slot and sub-cycle. The bench drives inputs and samples outputs on falling edges. It waits for `frame_start`, then compares all 4·m cycles against an expected pattern built from m and p_i. It also requires the next `frame_start` exactly 4·m cycles later. To test the boundary rule, a setting is changed in the first cycle of a frame, after that frame has already latched its values. The bench then expects the old pattern for that frame and the new pattern for the following one.

// File: rtl/nupc_pkg.sv
package nupc_pkg;
  // Four fast cycles per master period; the order is what guarantees non-overlap
  typedef enum logic [1:0] {
    SUB_PH1   = 2'd0,
    SUB_GAP_A = 2'd1,
    SUB_PH2   = 2'd2,
    SUB_GAP_B = 2'd3
  } sub_e;

  function automatic sub_e sub_advance(input sub_e cur);
    case (cur)
      SUB_PH1:   return SUB_GAP_A;
      SUB_GAP_A: return SUB_PH2;
      SUB_PH2:   return SUB_GAP_B;
      default:   return SUB_PH1;
    endcase
  endfunction
endpackage

// File: rtl/nupc_frame_seq.sv
module nupc_frame_seq
  import nupc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] frame_len,
  output logic             boundary,
  output sub_e             sub_nx,
  output logic [CNT_W-1:0] slot_nx,
  output logic [CNT_W-1:0] m_nx,
  output logic [CNT_W-1:0] m_cur,
  output logic             frame_start
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             run_q;
  sub_e             sub_q;
  logic [CNT_W-1:0] slot_q;
  logic [CNT_W-1:0] m_q;

  always_comb begin
    boundary = !run_q || (sub_q == SUB_GAP_B && slot_q >= m_q);
    sub_nx   = boundary ? SUB_PH1 : sub_advance(sub_q);
    m_nx     = boundary ? ((frame_len == '0) ? ONE : frame_len) : m_q;
    if (boundary)
      slot_nx = ONE;
    else if (sub_q == SUB_GAP_B)
      slot_nx = slot_q + ONE;
    else
      slot_nx = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      sub_q       <= SUB_GAP_B;
      slot_q      <= '0;
      m_q         <= ONE;
      frame_start <= 1'b0;
    end else begin
      run_q       <= 1'b1;
      sub_q       <= sub_nx;
      slot_q      <= slot_nx;
      m_q         <= m_nx;
      frame_start <= boundary;
    end
  end

  assign m_cur = m_q;

  // R1: the slot index stays within the frame it belongs to
  assert_slot_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (slot_q >= ONE && slot_q <= m_q));

  // R6: the frame length only moves at a boundary
  assert_len_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !boundary) |=> $stable(m_q));

  // R8: the strobe lasts one cycle
  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
endmodule

// File: rtl/nupc_branch_gate.sv
module nupc_branch_gate
  import nupc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  sub_e             sub_nx,
  input  logic [CNT_W-1:0] slot_nx,
  input  logic [CNT_W-1:0] m_nx,
  input  logic [CNT_W-1:0] m_cur,
  input  logic [CNT_W-1:0] cnt_raw,
  output logic             ph1,
  output logic             ph2,
  output logic             clamp_flag
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] p_q, p_nx, cnt_fix;
  logic             over, act;

  always_comb begin
    over    = (cnt_raw == '0) || (cnt_raw > m_nx);
    cnt_fix = (cnt_raw == '0) ? ONE : ((cnt_raw > m_nx) ? m_nx : cnt_raw);
    p_nx    = boundary ? cnt_fix : p_q;
    act     = (slot_nx <= p_nx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q        <= ONE;
      ph1        <= 1'b0;
      ph2        <= 1'b0;
      clamp_flag <= 1'b0;
    end else begin
      p_q        <= p_nx;
      ph1        <= act && (sub_nx == SUB_PH1);
      ph2        <= act && (sub_nx == SUB_PH2);
      if (boundary)
        clamp_flag <= over;
    end
  end

  // R4: the two phases of this branch never coincide
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph1 && ph2));

  // R3: a phase 1 pulse is followed by a dead cycle, then phase 2
  assert_dead_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ph1 |=> (!ph1 && !ph2));
  assert_pair_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ph1 |-> ##2 ph2);

  // R7: the latched count is always legal for the running frame
  assert_count_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (p_q >= ONE && p_q <= m_cur));

  // R6: the count only moves at a boundary
  assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(p_q));
endmodule

// File: rtl/nupc_phase_gen.sv
module nupc_phase_gen
  import nupc_pkg::*;
#(
  parameter int N_BR  = 4,
  parameter int CNT_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-1:0]        frame_len,
  input  logic [N_BR*CNT_W-1:0]   pulse_cnt,
  output logic [N_BR-1:0]         br_ph1,
  output logic [N_BR-1:0]         br_ph2,
  output logic                    fix_ph1,
  output logic                    fix_ph2,
  output logic                    frame_start,
  output logic [N_BR-1:0]         clamp_flag
);
  logic             boundary;
  sub_e             sub_nx;
  logic [CNT_W-1:0] slot_nx, m_nx, m_cur;

  nupc_frame_seq #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_len   (frame_len),
    .boundary    (boundary),
    .sub_nx      (sub_nx),
    .slot_nx     (slot_nx),
    .m_nx        (m_nx),
    .m_cur       (m_cur),
    .frame_start (frame_start)
  );

  for (genvar gi = 0; gi < N_BR; gi++) begin : g_br
    nupc_branch_gate #(.CNT_W(CNT_W)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .boundary   (boundary),
      .sub_nx     (sub_nx),
      .slot_nx    (slot_nx),
      .m_nx       (m_nx),
      .m_cur      (m_cur),
      .cnt_raw    (pulse_cnt[gi*CNT_W +: CNT_W]),
      .ph1        (br_ph1[gi]),
      .ph2        (br_ph2[gi]),
      .clamp_flag (clamp_flag[gi])
    );
  end

  // Always-active pair: one pulse per phase in every slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_ph1 <= 1'b0;
      fix_ph2 <= 1'b0;
    end else begin
      fix_ph1 <= (sub_nx == SUB_PH1);
      fix_ph2 <= (sub_nx == SUB_PH2);
    end
  end

  // R5: every phase 1 pulse of the shared pair is followed by phase 2
  assert_fix_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fix_ph1 |-> ##2 fix_ph2);

  // R4: shared pair never overlaps
  assert_fix_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fix_ph1 && fix_ph2));

  // R8: the strobe coincides with a phase 1 pulse of the shared pair
  assert_strobe_on_ph1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> fix_ph1);
endmodule

// File: tb/nupc_phase_gen_bench.sv
module nupc_phase_gen_bench;
  localparam int NB = 4;
  localparam int W  = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [W-1:0]    frame_len = '0;
  logic [NB*W-1:0] pulse_cnt = '0;
  logic [NB-1:0]   br_ph1, br_ph2, clamp_flag;
  logic            fix_ph1, fix_ph2, frame_start;

  nupc_phase_gen #(.N_BR(NB), .CNT_W(W)) u_nupc_phase_gen (
    .clk(clk), .rst_n(rst_n), .frame_len(frame_len), .pulse_cnt(pulse_cnt),
    .br_ph1(br_ph1), .br_ph2(br_ph2), .fix_ph1(fix_ph1), .fix_ph2(fix_ph2),
    .frame_start(frame_start), .clamp_flag(clamp_flag)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int m, input int p [NB]);
    frame_len = W'(m);
    for (int i = 0; i < NB; i++) pulse_cnt[i*W +: W] = W'(p[i]);
  endtask

  task automatic sync_frame();
    int n = 0;
    while (frame_start !== 1'b1 && n < 400) begin
      @(negedge clk);
      n++;
    end
    if (frame_start !== 1'b1) check(1'b0, "R8 frame strobe never seen", 0, 1);
  endtask

  // Starts on the negedge of a frame's first cycle; ends on the next one
  task automatic check_frame(input int m, input int pe [NB], input bit fl [NB], input string tag);
    int pc1 [NB];
    int pc2 [NB];
    int mis = 0, ovl = 0, fsc = 0, fmis = 0, fix1 = 0, flmis = 0;
    for (int i = 0; i < NB; i++) begin pc1[i] = 0; pc2[i] = 0; end
    for (int k = 0; k < 4*m; k++) begin
      int sub  = k % 4;
      int slot = k / 4 + 1;
      for (int i = 0; i < NB; i++) begin
        bit e1 = (sub == 0) && (slot <= pe[i]);
        bit e2 = (sub == 2) && (slot <= pe[i]);
        if (br_ph1[i] !== e1 || br_ph2[i] !== e2) mis++;
        if (br_ph1[i] && br_ph2[i]) ovl++;
        if (clamp_flag[i] !== fl[i]) flmis++;
        pc1[i] += int'(br_ph1[i]);
        pc2[i] += int'(br_ph2[i]);
      end
      if (fix_ph1 !== (sub == 0) || fix_ph2 !== (sub == 2)) fmis++;
      if (fix_ph1 && fix_ph2) ovl++;
      fix1 += int'(fix_ph1);
      if (frame_start === 1'b1) fsc++;
      if (frame_start !== (k == 0)) fmis++;
      @(negedge clk);
    end
    check(frame_start === 1'b1, {tag, " R1 next frame after 4m cycles"}, int'(frame_start), 1);
    for (int i = 0; i < NB; i++) begin
      check(pc1[i] == pe[i], $sformatf("%s R2 ph1 pulses br%0d", tag, i), pc1[i], pe[i]);
      check(pc2[i] == pe[i], $sformatf("%s R2 ph2 pulses br%0d", tag, i), pc2[i], pe[i]);
    end
    check(mis == 0, {tag, " R3 slot pattern mismatches"}, mis, 0);
    check(ovl == 0, {tag, " R4 overlapping cycles"}, ovl, 0);
    check(fix1 == m, {tag, " R5 shared pair pulses"}, fix1, m);
    check(fmis == 0, {tag, " R5/R8 shared pair and strobe mismatches"}, fmis, 0);
    check(fsc == 1, {tag, " R8 strobe cycles per frame"}, fsc, 1);
    check(flmis == 0, {tag, " R7 clamp flag mismatches"}, flmis, 0);
  endtask

  // Apply new settings and move to the first frame that uses them
  task automatic apply_and_sync(input int m, input int p [NB]);
    set_cfg(m, p);
    @(negedge clk);
    sync_frame();
  endtask

  task automatic t_reset_r9();
    int p [NB] = '{3, 8, 1, 5};
    bit f [NB] = '{0, 0, 0, 0};
    set_cfg(8, p);
    repeat (3) @(negedge clk);
    check({br_ph1, br_ph2, fix_ph1, fix_ph2, frame_start, clamp_flag} == '0,
          "R9 outputs low in reset", int'({br_ph1, br_ph2}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(frame_start === 1'b1, "R9 first frame on first edge", int'(frame_start), 1);
    check(br_ph1 === 4'b1111, "R9 first slot phase 1", int'(br_ph1), 15);
    check_frame(8, p, f, "reset m8");
  endtask

  task automatic t_len24_r1();
    int p [NB] = '{24, 12, 1, 7};
    bit f [NB] = '{0, 0, 0, 0};
    apply_and_sync(24, p);
    check_frame(24, p, f, "m24");
  endtask

  task automatic t_len32_r1();
    int p [NB] = '{31, 2, 32, 16};
    bit f [NB] = '{0, 0, 0, 0};
    apply_and_sync(32, p);
    check_frame(32, p, f, "m32");
  endtask

  task automatic t_clamp_r7();
    int p  [NB] = '{0, 40, 9, 8};
    int pe [NB] = '{1, 8, 8, 8};
    bit f  [NB] = '{1, 1, 1, 0};
    apply_and_sync(8, p);
    check_frame(8, pe, f, "clamp");
  endtask

  task automatic t_zero_len_r1();
    int p  [NB] = '{1, 5, 0, 1};
    int pe [NB] = '{1, 1, 1, 1};
    bit f  [NB] = '{0, 1, 1, 0};
    apply_and_sync(0, p);
    check_frame(1, pe, f, "len0");
    check_frame(1, pe, f, "len0 repeat");
  endtask

  task automatic t_boundary_r6();
    int pa [NB] = '{2, 4, 6, 8};
    int pb [NB] = '{1, 2, 3, 6};
    bit f  [NB] = '{0, 0, 0, 0};
    apply_and_sync(8, pa);
    // this frame has already latched pa; a change now must wait
    set_cfg(6, pb);
    check_frame(8, pa, f, "R6 frame in progress keeps old");
    check_frame(6, pb, f, "R6 next frame takes new");
  endtask

  initial begin
    fork
      begin
        t_reset_r9();
        t_len24_r1();
        t_len32_r1();
        t_clamp_r7();
        t_zero_len_r1();
        t_boundary_r6();
      end
      begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule